// File: doc/BRIEF.md
# Exception Vector Address Generator

This block turns an exception number into the address of its entry in a relocatable table of handler addresses, reads that one word through a simple request/response memory port, and hands the fetched word onward. The table holds addresses, not code. Each entry is one 32-bit word, and the entry for exception `n` sits at `base + 4*n`.

When reset is released, the block runs a two-step boot without being asked. First it reads entry 0, which holds the initial main stack pointer, and presents that value. Only after that value has been accepted does it read entry 1, which holds the reset handler address. After boot it accepts one exception number at a time. A number with no usable entry is rejected: the block reports an error flag and makes no memory access. Software moves the table by writing a base register whose low seven bits always read as zero.

All three data paths use valid/ready handshakes: exception number in, memory request out, result out. A transfer takes place on a rising clock edge where both valid and ready are high. Once valid is raised it stays high, with its payload unchanged, until the transfer takes place. The memory response channel is accepted only while the block waits for a read. The configuration write port is a plain strobe.

Top module: `vecgen_top`

## Requirements
- R1: After reset the first memory request is a read of address `base + 0` with the base at zero. Its data is presented on the result channel with `out_sp`=1 and `out_err`=0.
- R2: The read of entry 1 (address `base + 4`) is not issued until the stack-pointer result has been accepted. Its data is then presented with `out_sp`=0 and `out_err`=0.
- R3: `req_ready` is high only when no boot step, fetch or result is outstanding. For an accepted legal number `n`, exactly one read of `base + 4*n` is issued, and the returned word is presented with `out_sp`=0 and `out_err`=0.
- R4: These numbers are illegal: 0, 7 to 10, 13, and any value at or above the table size of `EXT_LINES + 16` words. An illegal number gives a result with `out_err`=1, `out_data`=0 and `out_sp`=0, and no memory request is issued.
- R5: The base register resets to zero. A write stores the written value with bits [6:0] cleared.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_addr` does not change.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sp` and `out_err` do not change.
- R8: A base write made while a read is pending does not change that read's address. It applies to the next accepted number.
- R9: `mem_rsp_ready` is high only while a read has been issued and its response has not yet arrived. While it is high, neither `mem_req_valid` nor `out_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the boot sequence |
| req_valid | input | 1 | Exception number offered |
| req_ready | output | 1 | Block idle and able to take a number |
| req_num | input | NUM_W | Exception number |
| cfg_wr_en | input | 1 | Base register write strobe |
| cfg_wr_data | input | AW | Base register write value |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waiting for read data |
| mem_rsp_data | input | AW | Read data |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | AW | Fetched word, or zero on error |
| out_sp | output | 1 | Result is the initial stack pointer |
| out_err | output | 1 | Number was rejected; no read was made |

## Verification
The hardest case to reach from the ports is a base write that lands while a read is stalled on `mem_req_ready`. The bench reaches it by holding the memory port back for several cycles after accepting a number. It writes the base during that stall and checks that the pending address does not move, then checks that the next number uses the new base. The ordering of the boot sequence is also tested under pressure: the stack-pointer result is held unaccepted for several cycles while the bench checks that no second read appears. Every exception number from 0 past the end of the table is swept under two bases, with the stall lengths varied from one number to the next.

// File: rtl/vecgen_pkg.sv
package vecgen_pkg;

  typedef enum logic [1:0] {
    ST_ISSUE   = 2'd0,
    ST_WAIT    = 2'd1,
    ST_PRESENT = 2'd2,
    ST_IDLE    = 2'd3
  } vg_state_e;

  typedef enum logic [1:0] {
    PH_STACK = 2'd0,
    PH_BOOT  = 2'd1,
    PH_EXC   = 2'd2
  } vg_phase_e;

  localparam int unsigned SYS_ENTRIES = 16;
  localparam int unsigned BASE_ALIGN  = 7;

  function automatic logic entry_reserved(input int unsigned n);
    return (n == 0) || (n >= 7 && n <= 10) || (n == 13);
  endfunction

endpackage

// File: rtl/vecgen_base_reg.sv
module vecgen_base_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base
);
  import vecgen_pkg::*;

  localparam int unsigned KEEP = AW - BASE_ALIGN;

  logic [KEEP-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_en) hi_q <= wr_data[AW-1:BASE_ALIGN];
  end

  assign base = {hi_q, {BASE_ALIGN{1'b0}}};

endmodule

// File: rtl/vecgen_decode.sv
module vecgen_decode #(
  parameter int unsigned AW          = 32,
  parameter int unsigned NUM_W       = 8,
  parameter int unsigned TABLE_WORDS = 24
) (
  input  logic [AW-1:0]    base,
  input  logic [NUM_W-1:0] num,
  output logic             legal,
  output logic [AW-1:0]    entry_addr
);
  import vecgen_pkg::*;

  localparam int unsigned PAD = AW - NUM_W - 2;

  always_comb begin
    legal      = (int'(num) < TABLE_WORDS) && !entry_reserved(int'(num));
    entry_addr = base + {{PAD{1'b0}}, num, 2'b00};
  end

endmodule

// File: rtl/vecgen_seq.sv
module vecgen_seq #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          dec_legal,
  input  logic [AW-1:0] dec_addr,
  output logic          boot_sel,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data,
  output logic          out_sp,
  output logic          out_err
);
  import vecgen_pkg::*;

  vg_state_e     state_q;
  vg_phase_e     phase_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] data_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ISSUE;
      phase_q <= PH_STACK;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          data_q  <= mem_rsp_data;
          err_q   <= 1'b0;
          state_q <= ST_PRESENT;
        end
        ST_PRESENT: if (out_ready) begin
          if (phase_q == PH_STACK) begin
            phase_q <= PH_BOOT;
            addr_q  <= dec_addr;
            state_q <= ST_ISSUE;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: if (req_valid) begin
          phase_q <= PH_EXC;
          if (dec_legal) begin
            addr_q  <= dec_addr;
            state_q <= ST_ISSUE;
          end else begin
            err_q   <= 1'b1;
            data_q  <= '0;
            state_q <= ST_PRESENT;
          end
        end
      endcase
    end
  end

  assign boot_sel      = (phase_q == PH_STACK);
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_addr      = addr_q;
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign out_valid     = (state_q == ST_PRESENT);
  assign out_data      = data_q;
  assign out_sp        = (phase_q == PH_STACK);
  assign out_err       = err_q;

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sp) && $stable(out_err));

  a_r4_reject_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dec_legal |=> out_valid && out_err && !mem_req_valid);

  a_r2_stack_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) && !out_sp && $past(out_sp) |-> $past(out_valid && out_ready));

  a_r9_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid && !out_valid);

endmodule

// File: rtl/vecgen_top.sv
module vecgen_top #(
  parameter int unsigned AW        = 32,
  parameter int unsigned NUM_W     = 8,
  parameter int unsigned EXT_LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NUM_W-1:0] req_num,
  input  logic             cfg_wr_en,
  input  logic [AW-1:0]    cfg_wr_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [AW-1:0]    mem_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_data,
  output logic             out_sp,
  output logic             out_err
);
  import vecgen_pkg::*;

  localparam int unsigned TABLE_WORDS = EXT_LINES + SYS_ENTRIES;

  logic [AW-1:0]    base;
  logic             boot_sel;
  logic [NUM_W-1:0] dec_num;
  logic             dec_legal;
  logic [AW-1:0]    dec_addr;

  assign dec_num = boot_sel ? NUM_W'(1) : req_num;

  vecgen_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .base(base)
  );

  vecgen_decode #(.AW(AW), .NUM_W(NUM_W), .TABLE_WORDS(TABLE_WORDS)) u_dec (
    .base(base), .num(dec_num), .legal(dec_legal), .entry_addr(dec_addr)
  );

  vecgen_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .dec_legal(dec_legal), .dec_addr(dec_addr), .boot_sel(boot_sel),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sp(out_sp), .out_err(out_err)
  );

  a_r3_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !out_valid && !mem_rsp_ready);

endmodule

// File: tb/sim_vecgen_top.sv
module sim_vecgen_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 32;
  localparam int unsigned NUM_W = 8;
  localparam int unsigned EXT_LINES = 8;
  localparam int unsigned TWORDS = EXT_LINES + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [NUM_W-1:0] req_num = '0;
  logic cfg_wr_en = 1'b0;
  logic [AW-1:0] cfg_wr_data = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_ready;
  logic [AW-1:0] mem_rsp_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [AW-1:0] out_data;
  logic out_sp;
  logic out_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vecgen_top #(.AW(AW), .NUM_W(NUM_W), .EXT_LINES(EXT_LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_num(req_num),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sp(out_sp), .out_err(out_err)
  );

  function automatic logic [AW-1:0] memword(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] + 16'h0101};
  endfunction

  function automatic bit legal_num(input int n);
    return n >= 1 && n < int'(TWORDS) && !(n >= 7 && n <= 10) && n != 13;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic send_req(input int n);
    req_valid = 1'b1;
    req_num = NUM_W'(n);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic serve_mem(input logic [AW-1:0] exp_addr, input int stall, input int lat, input string req);
    while (!mem_req_valid) @(negedge clk);
    chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_addr == exp_addr, "R6 request held", mem_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_rsp_ready && !mem_req_valid && !out_valid, "R9 waiting for response",
        AW'(mem_rsp_ready), AW'(1));
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = memword(exp_addr);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    chk(!mem_rsp_ready, "R9 response port closed", AW'(mem_rsp_ready), AW'(0));
  endtask

  task automatic take_out(input logic [AW-1:0] exp_d, input bit exp_sp, input bit exp_err,
                          input int stall, input string req);
    while (!out_valid) @(negedge clk);
    chk(out_data == exp_d && out_sp == exp_sp && out_err == exp_err, req,
        {out_data[AW-3:0], out_sp, out_err}, {exp_d[AW-3:0], exp_sp, exp_err});
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == exp_d && out_sp == exp_sp && out_err == exp_err,
          "R7 result held", out_data, exp_d);
      if (exp_sp) chk(!mem_req_valid, "R2 no vector read before stack pointer taken",
                      AW'(mem_req_valid), AW'(0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic write_base(input logic [AW-1:0] v);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic one_fetch(input int n, input logic [AW-1:0] base, input int k);
    send_req(n);
    if (legal_num(n)) begin
      serve_mem(base + AW'(4 * n), k % 3, (k + 1) % 2, "R3 entry address");
      take_out(memword(base + AW'(4 * n)), 1'b0, 1'b0, k % 2, "R3 fetched handler");
    end else begin
      chk(!mem_req_valid && out_valid, "R4 rejected without read", AW'(mem_req_valid), AW'(0));
      take_out('0, 1'b0, 1'b1, k % 2, "R4 error result");
    end
    chk(req_ready, "R3 idle after result", AW'(req_ready), AW'(1));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R1
    chk(mem_req_valid && mem_addr == '0, "R1 first read at entry 0", mem_addr, '0);
    chk(!req_ready && !out_valid, "R3 not ready during boot", AW'(req_ready), AW'(0));
    serve_mem('0, 2, 1, "R1 stack pointer address");
    take_out(memword('0), 1'b1, 1'b0, 3, "R1 stack pointer result");
    serve_mem(AW'(4), 1, 0, "R2 reset vector address");
    take_out(memword(AW'(4)), 1'b0, 1'b0, 1, "R2 reset vector result");
    chk(req_ready, "R3 ready after boot", AW'(req_ready), AW'(1));

    // R5: reset base is zero, low bits ignored
    write_base(AW'(32'h0000_007F));
    one_fetch(3, '0, 0);

    // sweep under two bases
    for (int pass = 0; pass < 2; pass++) begin
      b = (pass == 0) ? '0 : 32'h2000_0080;
      if (pass == 1) write_base(32'h2000_00FF); // R5 low seven bits cleared
      for (int n = 0; n < int'(TWORDS) + 6; n++) one_fetch(n, b, n + pass);
      one_fetch(255, b, 1);
    end

    // R8: base write while request stalled
    send_req(16);
    while (!mem_req_valid) @(negedge clk);
    write_base(32'h0001_0000);
    chk(mem_req_valid && mem_addr == 32'h2000_0080 + 64, "R8 pending address unchanged",
        mem_addr, 32'h2000_00C0);
    serve_mem(32'h2000_00C0, 2, 1, "R8 pending read");
    take_out(memword(32'h2000_00C0), 1'b0, 1'b0, 0, "R8 pending result");
    one_fetch(16, 32'h0001_0000, 2);
    one_fetch(13, 32'h0001_0000, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule